// File: doc/BRIEF.md
# Serial Flash Buffer-Write Command Front End

This block is the command receiver of a dual-buffer serial flash model. It watches an SPI slave bus (mode 0, data taken on the rising serial clock while chip select is low), gathers an opcode byte and three address bytes, and then acts on the command. A buffer-load command picks one of two page buffers and a start offset. Every complete data byte after that is sent out on one shared write port, at consecutive offsets. The offset wraps inside the page until chip select goes high.

A page-program command, with or without a built-in erase, is only decoded here. When chip select rises, the block passes the source buffer, the erase choice and the 13-bit page number to a separate program sequencer as a single-cycle pulse. A mode input chooses a 528-byte or a 512-byte page, and this choice moves the address fields. The serial pins are synchronised into the system clock domain, so the serial clock must run several times slower than `clk`.

Top module: `flashCmdFront`

## Requirements
- R1: Bits are taken MSB first. Opcode 84h sends data bytes to buffer 1 (`bufWrSel`=0) and opcode 87h sends them to buffer 2 (`bufWrSel`=1).
- R2: With `pageMode528`=1, the start offset is bits 9:0 of the 24-bit address (the first address byte is bits 23:16). Bits 23:10 are ignored.
- R3: With `pageMode528`=0, the start offset is bits 8:0 of the 24-bit address. Bits 23:9 are ignored.
- R4: The first data byte is the byte right after the third address byte. Each complete data byte gives exactly one `bufWrEn` pulse, with the byte on `bufWrData`, at offsets that rise by one.
- R5: After offset 527 (528 mode) or offset 511 (512 mode), the next byte goes to offset 0.
- R6: Writing stops when chip select rises. A partial byte of fewer than 8 bits at that moment is dropped.
- R7: Opcodes 83h/86h give a program request with erase (`progErase`=1), and 88h/89h give one without erase (`progErase`=0). The first of each pair gives `progBufSel`=0 and the second gives 1. The request is a one-cycle `progValid` pulse after chip select rises.
- R8: The program page number is address bits 22:10 in 528 mode and bits 21:9 in 512 mode.
- R9: An unknown opcode, or chip select rising before all three address bytes have arrived, causes no write and no program request.
- R10: If `busy` is high when chip select rises, a program command is dropped. Buffer loads still work while `busy` is high.
- R11: Out of reset, `bufWrEn` and `progValid` are low and all output fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSck | input | 1 | Serial clock, sampled by `clk` |
| spiCsN | input | 1 | Active-low chip select |
| spiSi | input | 1 | Serial data in |
| pageMode528 | input | 1 | 1: 528-byte page, 0: 512-byte page |
| busy | input | 1 | Program sequencer busy |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrSel | output | 1 | Target buffer (0 = buffer 1) |
| bufWrAddr | output | 10 | Byte offset in the buffer |
| bufWrData | output | 8 | Byte to write |
| progValid | output | 1 | Program request pulse |
| progBufSel | output | 1 | Source buffer (0 = buffer 1) |
| progErase | output | 1 | Erase the page before programming |
| progPage | output | 13 | Target page number |

## Verification
The assertions assume that the serial clock's high and low phases each last several `clk` cycles. They also assume that chip select stays high, and stays low, for several cycles around every edge, and that `pageMode528` only changes while chip select is high. In addition, a load command's start offset must lie inside the selected page. The stimulus produces each serial edge after four `clk` periods. It frames each transaction with six idle cycles on each side, changes the mode only between transactions, and picks start offsets only inside the page.

// File: rtl/flashFePkg.sv
package flashFePkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPCODE,
    PH_ADDR,
    PH_DATA,
    PH_DROP
  } phase_t;

  typedef struct packed {
    logic clearBits;
    logic shiftAddr;
    logic loadPtr;
    logic writeByte;
    logic issueProg;
    logic bufSel;
    logic eraseFirst;
  } feStrobe_t;

  localparam logic [7:0] OP_LOAD_ONE   = 8'h84;
  localparam logic [7:0] OP_LOAD_TWO   = 8'h87;
  localparam logic [7:0] OP_ERPRG_ONE  = 8'h83;
  localparam logic [7:0] OP_ERPRG_TWO  = 8'h86;
  localparam logic [7:0] OP_PRG_ONE    = 8'h88;
  localparam logic [7:0] OP_PRG_TWO    = 8'h89;

endpackage

// File: rtl/feSampler.sv
module feSampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic siIn,
  output logic sckRise,
  output logic csRise,
  output logic csFall,
  output logic csActive,
  output logic siBit
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sckPipe;
  logic [TOP:0] csPipe;
  logic [TOP:0] siPipe;
  logic         sckLast;
  logic         csLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      siPipe  <= '0;
      sckLast <= 1'b0;
      csLast  <= 1'b1;
    end else begin
      sckPipe <= {sckPipe[TOP-1:0], sckIn};
      csPipe  <= {csPipe[TOP-1:0], csNIn};
      siPipe  <= {siPipe[TOP-1:0], siIn};
      sckLast <= sckPipe[TOP];
      csLast  <= csPipe[TOP];
    end
  end

  assign sckRise  = sckPipe[TOP] & ~sckLast;
  assign csRise   = csPipe[TOP] & ~csLast;
  assign csFall   = ~csPipe[TOP] & csLast;
  assign csActive = ~csPipe[TOP];
  assign siBit    = siPipe[TOP];

endmodule

// File: rtl/feDatapath.sv
module feDatapath
  import flashFePkg::*;
#(
  parameter int BIG_BYTES = 528,
  parameter int OFFSET_W  = 10,
  parameter int PAGE_W    = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sckRise,
  input  logic                csActive,
  input  logic                siBit,
  input  logic                pageMode528,
  input  feStrobe_t           strobe,
  output logic                byteDone,
  output logic [7:0]          byteNow,
  output logic                bufWrEn,
  output logic                bufWrSel,
  output logic [OFFSET_W-1:0] bufWrAddr,
  output logic [7:0]          bufWrData,
  output logic                progValid,
  output logic                progBufSel,
  output logic                progErase,
  output logic [PAGE_W-1:0]   progPage
);
  localparam int ADDR_USED = OFFSET_W + PAGE_W;
  localparam int HOLD_W    = ADDR_USED - 8;
  localparam logic [OFFSET_W-1:0] BIG_LAST   = OFFSET_W'(BIG_BYTES - 1);
  localparam logic [OFFSET_W-1:0] SMALL_LAST = OFFSET_W'((1 << (OFFSET_W - 1)) - 1);

  logic [2:0]           bitCnt;
  logic [7:0]           shReg;
  logic [HOLD_W-1:0]    addrHold;
  logic [OFFSET_W-1:0]  ptr;
  logic [OFFSET_W-1:0]  ptrNext;
  logic [OFFSET_W-1:0]  lastIdx;
  logic                 modeHold;
  logic [PAGE_W-1:0]    pageHold;
  logic [ADDR_USED-1:0] fullAddr;
  logic [OFFSET_W-1:0]  startOff;
  logic [PAGE_W-1:0]    pageNow;

  assign byteNow  = {shReg[6:0], siBit};
  assign byteDone = sckRise & csActive & (bitCnt == 3'd7);
  assign fullAddr = {addrHold, byteNow};

  always_comb begin
    if (pageMode528) begin
      startOff = fullAddr[OFFSET_W-1:0];
      pageNow  = fullAddr[OFFSET_W +: PAGE_W];
    end else begin
      startOff = {1'b0, fullAddr[OFFSET_W-2:0]};
      pageNow  = fullAddr[OFFSET_W-1 +: PAGE_W];
    end
  end

  assign lastIdx = modeHold ? BIG_LAST : SMALL_LAST;
  assign ptrNext = (ptr >= lastIdx) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else if (strobe.clearBits) begin
      bitCnt <= '0;
    end else if (sckRise && csActive) begin
      bitCnt <= bitCnt + 3'd1;
      shReg  <= byteNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      ptr      <= '0;
      modeHold <= 1'b1;
      pageHold <= '0;
    end else if (strobe.shiftAddr) begin
      addrHold <= {addrHold[HOLD_W-9:0], byteNow};
    end else if (strobe.loadPtr) begin
      ptr      <= startOff;
      modeHold <= pageMode528;
      pageHold <= pageNow;
    end else if (strobe.writeByte) begin
      ptr      <= ptrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufWrEn    <= 1'b0;
      bufWrSel   <= 1'b0;
      bufWrAddr  <= '0;
      bufWrData  <= '0;
      progValid  <= 1'b0;
      progBufSel <= 1'b0;
      progErase  <= 1'b0;
      progPage   <= '0;
    end else begin
      bufWrEn   <= strobe.writeByte;
      progValid <= strobe.issueProg;
      if (strobe.writeByte) begin
        bufWrSel  <= strobe.bufSel;
        bufWrAddr <= ptr;
        bufWrData <= byteNow;
      end
      if (strobe.issueProg) begin
        progBufSel <= strobe.bufSel;
        progErase  <= strobe.eraseFirst;
        progPage   <= pageHold;
      end
    end
  end

endmodule

// File: rtl/feControl.sv
module feControl
  import flashFePkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csRise,
  input  logic       csFall,
  input  logic       byteDone,
  input  logic [7:0] byteNow,
  input  logic       busy,
  output feStrobe_t  strobe
);
  localparam int CNT_W = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES - 1);

  phase_t           phase;
  logic             isProg;
  logic             bufSelR;
  logic             eraseR;
  logic [CNT_W-1:0] addrCnt;

  always_comb begin
    strobe            = '0;
    strobe.bufSel     = bufSelR;
    strobe.eraseFirst = eraseR;
    if (csRise) begin
      strobe.clearBits = 1'b1;
      strobe.issueProg = (phase == PH_DATA) && isProg && !busy;
    end else if (csFall) begin
      strobe.clearBits = 1'b1;
    end else if (byteDone) begin
      case (phase)
        PH_ADDR: begin
          if (addrCnt == LAST_ADDR) strobe.loadPtr = 1'b1;
          else                      strobe.shiftAddr = 1'b1;
        end
        PH_DATA: strobe.writeByte = !isProg;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      isProg  <= 1'b0;
      bufSelR <= 1'b0;
      eraseR  <= 1'b0;
      addrCnt <= '0;
    end else if (csRise) begin
      phase <= PH_IDLE;
    end else if (csFall) begin
      phase   <= PH_OPCODE;
      addrCnt <= '0;
    end else if (byteDone) begin
      case (phase)
        PH_OPCODE: begin
          phase <= PH_ADDR;
          case (byteNow)
            OP_LOAD_ONE:  begin isProg <= 1'b0; bufSelR <= 1'b0; eraseR <= 1'b0; end
            OP_LOAD_TWO:  begin isProg <= 1'b0; bufSelR <= 1'b1; eraseR <= 1'b0; end
            OP_ERPRG_ONE: begin isProg <= 1'b1; bufSelR <= 1'b0; eraseR <= 1'b1; end
            OP_ERPRG_TWO: begin isProg <= 1'b1; bufSelR <= 1'b1; eraseR <= 1'b1; end
            OP_PRG_ONE:   begin isProg <= 1'b1; bufSelR <= 1'b0; eraseR <= 1'b0; end
            OP_PRG_TWO:   begin isProg <= 1'b1; bufSelR <= 1'b1; eraseR <= 1'b0; end
            default:      phase <= PH_DROP;
          endcase
        end
        PH_ADDR: begin
          if (addrCnt == LAST_ADDR) phase <= PH_DATA;
          else                      addrCnt <= addrCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flashCmdFront.sv
module flashCmdFront
  import flashFePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BIG_BYTES   = 528,
  parameter int OFFSET_W    = 10,
  parameter int PAGE_W      = 13,
  parameter int ADDR_BYTES  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                spiSck,
  input  logic                spiCsN,
  input  logic                spiSi,
  input  logic                pageMode528,
  input  logic                busy,
  output logic                bufWrEn,
  output logic                bufWrSel,
  output logic [OFFSET_W-1:0] bufWrAddr,
  output logic [7:0]          bufWrData,
  output logic                progValid,
  output logic                progBufSel,
  output logic                progErase,
  output logic [PAGE_W-1:0]   progPage
);
  logic       sckRise;
  logic       csRise;
  logic       csFall;
  logic       csActive;
  logic       siBit;
  logic       byteDone;
  logic [7:0] byteNow;
  feStrobe_t  strobe;

  feSampler #(.SYNC_STAGES(SYNC_STAGES)) uSampler (
    .clk(clk), .rstN(rstN), .sckIn(spiSck), .csNIn(spiCsN), .siIn(spiSi),
    .sckRise(sckRise), .csRise(csRise), .csFall(csFall),
    .csActive(csActive), .siBit(siBit)
  );

  feControl #(.ADDR_BYTES(ADDR_BYTES)) uControl (
    .clk(clk), .rstN(rstN), .csRise(csRise), .csFall(csFall),
    .byteDone(byteDone), .byteNow(byteNow), .busy(busy), .strobe(strobe)
  );

  feDatapath #(.BIG_BYTES(BIG_BYTES), .OFFSET_W(OFFSET_W), .PAGE_W(PAGE_W)) uData (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .csActive(csActive),
    .siBit(siBit), .pageMode528(pageMode528), .strobe(strobe),
    .byteDone(byteDone), .byteNow(byteNow),
    .bufWrEn(bufWrEn), .bufWrSel(bufWrSel), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData), .progValid(progValid), .progBufSel(progBufSel),
    .progErase(progErase), .progPage(progPage)
  );

endmodule

// File: rtl/feFrontChecker.sv
module feFrontChecker #(
  parameter int BIG_BYTES = 528,
  parameter int OFFSET_W  = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                spiCsN,
  input logic                pageMode528,
  input logic                busy,
  input logic                bufWrEn,
  input logic [OFFSET_W-1:0] bufWrAddr,
  input logic                progValid
);
  localparam int SMALL_BYTES = 1 << (OFFSET_W - 1);

  // R10
  prog_busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    progValid |-> !$past(busy));

  // R7
  prog_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    progValid |=> !progValid);

  // R7
  prog_after_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    progValid |-> spiCsN);

  // R5
  wr_in_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (int'(bufWrAddr) < (pageMode528 ? BIG_BYTES : SMALL_BYTES)));

  // R6
  wr_while_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> !$past(spiCsN));

endmodule

bind flashCmdFront feFrontChecker #(.BIG_BYTES(BIG_BYTES), .OFFSET_W(OFFSET_W)) uChk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .pageMode528(pageMode528),
  .busy(busy), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .progValid(progValid)
);

// File: tb/sim_flashCmdFront.sv
module sim_flashCmdFront;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiSck = 1'b0;
  logic        spiCsN = 1'b1;
  logic        spiSi = 1'b0;
  logic        pageMode528 = 1'b1;
  logic        busy = 1'b0;
  logic        bufWrEn;
  logic        bufWrSel;
  logic [9:0]  bufWrAddr;
  logic [7:0]  bufWrData;
  logic        progValid;
  logic        progBufSel;
  logic        progErase;
  logic [12:0] progPage;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [18:0] expWr[$];
  string       wrTag[$];
  logic [14:0] expPg[$];
  string       pgTag[$];

  always #10 clk = ~clk;

  flashCmdFront u0 (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .pageMode528(pageMode528), .busy(busy),
    .bufWrEn(bufWrEn), .bufWrSel(bufWrSel), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData), .progValid(progValid), .progBufSel(progBufSel),
    .progErase(progErase), .progPage(progPage)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rstN && bufWrEn) begin
      if (expWr.size() == 0) check(1'b0, "R9 unexpected write", {13'd0, bufWrSel, bufWrAddr, bufWrData}, 32'hFFFF_FFFF);
      else begin
        logic [18:0] e;
        string t;
        e = expWr.pop_front();
        t = wrTag.pop_front();
        check({bufWrSel, bufWrAddr, bufWrData} == e, t, {13'd0, bufWrSel, bufWrAddr, bufWrData}, {13'd0, e});
      end
    end
    if (rstN && progValid) begin
      if (expPg.size() == 0) check(1'b0, "R9 R10 unexpected program", {17'd0, progBufSel, progErase, progPage}, 32'hFFFF_FFFF);
      else begin
        logic [14:0] e;
        string t;
        e = expPg.pop_front();
        t = pgTag.pop_front();
        check({progBufSel, progErase, progPage} == e, t, {17'd0, progBufSel, progErase, progPage}, {17'd0, e});
      end
    end
  end

  task automatic spiBit(input logic b);
    @(negedge clk) spiSi = b;
    repeat (4) @(negedge clk);
    spiSck = 1'b1;
    repeat (4) @(negedge clk);
    spiSck = 1'b0;
  endtask

  task automatic spiByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spiBit(b[i]);
  endtask

  task automatic csOpen();
    @(negedge clk) spiCsN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic csClose();
    repeat (6) @(negedge clk);
    spiCsN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic sendHead(input logic [7:0] op, input logic [23:0] addr);
    spiByte(op);
    spiByte(addr[23:16]);
    spiByte(addr[15:8]);
    spiByte(addr[7:0]);
  endtask

  // driver for buffer loads: pushes expected writes, then drives the bus
  task automatic doLoad(input logic [7:0] op, input logic [23:0] addr, input int n,
                        input logic [7:0] seed, input logic sel, input int start,
                        input int pageBytes, input string tag);
    logic [7:0] d [];
    int off;
    d = new[n];
    off = start;
    for (int k = 0; k < n; k++) begin
      d[k] = seed + 8'(k * 37);
      expWr.push_back({sel, 10'(off), d[k]});
      wrTag.push_back(tag);
      off = (off == pageBytes - 1) ? 0 : off + 1;
    end
    csOpen();
    sendHead(op, addr);
    for (int k = 0; k < n; k++) spiByte(d[k]);
    csClose();
  endtask

  task automatic doProg(input logic [7:0] op, input logic [23:0] addr, input bit go,
                        input logic sel, input logic erase, input logic [12:0] page,
                        input string tag);
    if (go) begin
      expPg.push_back({sel, erase, page});
      pgTag.push_back(tag);
    end
    csOpen();
    sendHead(op, addr);
    csClose();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check({bufWrEn, progValid, bufWrSel, bufWrAddr, bufWrData, progBufSel, progErase, progPage} == '0,
          "R11 reset outputs", {bufWrEn, progValid, bufWrAddr, bufWrData}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 R4: buffer 1, 528 mode, upper address bits all ones
    pageMode528 = 1'b1;
    doLoad(8'h84, 24'hFFFC05, 3, 8'hA1, 1'b0, 5, 528, "R1 R2 R4 load buffer 1");
    // R1 R5: buffer 2, wrap past 527
    doLoad(8'h87, 24'hABC20D, 5, 8'h3C, 1'b1, 525, 528, "R1 R5 wrap 528");
    // R3: 512 mode ignores bit 9
    pageMode528 = 1'b0;
    repeat (4) @(negedge clk);
    doLoad(8'h84, 24'hFFFE0A, 2, 8'h5A, 1'b0, 10, 512, "R3 offset 512");
    // R5: wrap past 511
    doLoad(8'h87, 24'h0003FE, 4, 8'hE7, 1'b1, 510, 512, "R3 R5 wrap 512");
    pageMode528 = 1'b1;
    repeat (4) @(negedge clk);

    // R6: partial trailing byte discarded
    expWr.push_back({1'b0, 10'd3, 8'h96});
    wrTag.push_back("R6 partial byte");
    csOpen();
    sendHead(8'h84, 24'h000003);
    spiByte(8'h96);
    for (int i = 0; i < 5; i++) spiBit(1'b1);
    csClose();
    // R4: next command starts aligned after partial byte
    doLoad(8'h87, 24'h000000, 2, 8'h11, 1'b1, 0, 528, "R4 R6 realign");

    // R7 R8: program commands, 528 layout
    doProg(8'h83, {1'b1, 13'h1ABC, 10'h3FF}, 1'b1, 1'b0, 1'b1, 13'h1ABC, "R7 R8 erase-prog buf1");
    doProg(8'h86, {1'b0, 13'h0123, 10'h155}, 1'b1, 1'b1, 1'b1, 13'h0123, "R7 R8 erase-prog buf2");
    doProg(8'h88, {1'b1, 13'h1FFF, 10'h000}, 1'b1, 1'b0, 1'b0, 13'h1FFF, "R7 R8 prog buf1");
    pageMode528 = 1'b0;
    repeat (4) @(negedge clk);
    doProg(8'h89, {2'b11, 13'h0A5A, 9'h1FF}, 1'b1, 1'b1, 1'b0, 13'h0A5A, "R7 R8 prog buf2 512");
    pageMode528 = 1'b1;
    repeat (4) @(negedge clk);

    // R9: unknown opcode with trailing bytes
    csOpen();
    sendHead(8'h12, 24'h000010);
    spiByte(8'h77);
    spiByte(8'h88);
    csClose();
    // R9: truncated address on load and program
    csOpen();
    spiByte(8'h84); spiByte(8'h00); spiByte(8'h00);
    csClose();
    csOpen();
    spiByte(8'h83); spiByte(8'h00); spiByte(8'h40);
    csClose();

    // R10: busy rejects program, allows load
    busy = 1'b1;
    doProg(8'h83, {1'b0, 13'h0777, 10'h0}, 1'b0, 1'b0, 1'b1, 13'h0777, "R10 busy reject");
    doLoad(8'h84, 24'h000100, 2, 8'hC3, 1'b0, 256, 528, "R10 load while busy");
    busy = 1'b0;
    doProg(8'h86, {1'b0, 13'h0042, 10'h0}, 1'b1, 1'b1, 1'b1, 13'h0042, "R10 program after busy");

    repeat (20) @(negedge clk);
    check(expWr.size() == 0, "R4 R9 writes outstanding", expWr.size(), 0);
    check(expPg.size() == 0, "R9 R10 programs outstanding", expPg.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule